// File: doc/BRIEF.md
# Page-Aware Transfer Chunker

This block splits one flash access request into a series of smaller sub-transfers that a flash cycle engine can run one at a time. A request carries a byte offset, a byte count and a page size. The block hands out chunk commands, each with an offset and a length. Each chunk holds no more bytes than the data FIFO can take. A chunk never runs past the end of the flash page it starts in, so a program cycle cannot wrap around inside a page.

The request side and the chunk side both use valid/ready handshakes. After a chunk is accepted, the block waits for the engine to report completion. A clean completion moves the offset forward and reduces the remaining count, and the next chunk is then offered. An error completion ends the whole request at once. When the request ends, a one-cycle finish pulse reports whether it succeeded or aborted.

A request of zero length still produces one chunk, of length zero. This serves commands that carry no data, such as an erase. The page size must be a power of two, and a page size of zero selects 256 bytes.

Top module: `xfer_chunker`

## Requirements
- R1: Each offered chunk length equals the smallest of three values: the bytes still remaining, FIFO_BYTES (default 64), and the distance from the chunk offset to the next page boundary.
- R2: For every offered chunk, (chk_offset mod page) + chk_len is at most page, so no chunk crosses a page boundary.
- R3: A req_page value of 0 is treated as a page size of 256 bytes.
- R4: The first chunk starts at req_offset. After each clean completion, the next chunk offset is the previous offset plus the previous length, and the chunk lengths of a successful request sum to req_len.
- R5: The completion that brings the remaining count to zero ends the request. In the following cycle fin_valid is 1 for exactly one cycle with fin_err 0, and req_ready is 1.
- R6: A completion with cmp_err 1 ends the request at once. In the following cycle fin_valid and fin_err are both 1, and no further chunk is offered.
- R7: A request with req_len 0 produces exactly one chunk, with chk_len 0. Its completion ends the request.
- R8: req_ready is 1 while idle. It stays 0 from the cycle after a request is accepted until the cycle after the final or failing completion.
- R9: While chk_valid is 1 and chk_ready is 0, chk_valid stays 1 and chk_offset and chk_len do not change.
- R10: A cmp_valid pulse while no accepted chunk is awaiting completion is ignored. The block keeps its idle or offering state and emits no finish pulse.
- R11: After reset, req_ready is 1, and chk_valid and fin_valid are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block is idle and will accept a request |
| req_offset | input | OFS_W | Start byte offset of the request |
| req_len | input | LEN_W | Total byte count of the request |
| req_page | input | PG_W | Page size in bytes, a power of two; 0 selects 256 |
| chk_valid | output | 1 | Chunk command offered |
| chk_ready | input | 1 | Engine takes the chunk command |
| chk_offset | output | OFS_W | Chunk start offset |
| chk_len | output | CHK_W | Chunk byte count |
| cmp_valid | input | 1 | Engine reports the end of the accepted chunk |
| cmp_err | input | 1 | With cmp_valid: the chunk failed |
| fin_valid | output | 1 | One-cycle pulse when a request ends |
| fin_err | output | 1 | With fin_valid: the request aborted on an error |

## Verification
The requests are chosen so that each one exercises a different limit on chunk length. An aligned long request is limited only by the FIFO. Misaligned starts are clipped first by the page edge and then by the FIFO. A long request starting in the middle of a page mixes both limits. A tiny page size makes the page edge the only limit. A page size of 0 checks the default. A zero-length request checks the single empty chunk, and an error on the second chunk checks the abort path. The engine is modelled with varying handshake delays, ready stalls and stray completion pulses. This separates correct chunk holding and ignored completions from designs that advance on the wrong handshake.

// File: rtl/xfer_chunker_pkg.sv
package xfer_chunker_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_OFFER = 2'd1,
    ST_WAIT  = 2'd2
  } chunk_state_e;

  // Smaller of two unsigned 32-bit values.
  function automatic logic [31:0] umin32(input logic [31:0] a, input logic [31:0] b);
    return (a < b) ? a : b;
  endfunction

  // Bytes from an offset up to the next boundary of a power-of-two page.
  function automatic logic [31:0] room_to_edge(input logic [31:0] off, input logic [31:0] pg);
    return pg - (off & (pg - 32'd1));
  endfunction

endpackage

// File: rtl/chunk_sizer.sv
module chunk_sizer #(
  parameter int OFS_W      = 32,
  parameter int LEN_W      = 16,
  parameter int PG_W       = 16,
  parameter int FIFO_BYTES = 64,
  parameter int CHK_W      = $clog2(FIFO_BYTES + 1)
) (
  input  logic [OFS_W-1:0] cur_off,
  input  logic [LEN_W-1:0] rem_bytes,
  input  logic [PG_W-1:0]  page_eff,
  output logic [CHK_W-1:0] next_len
);
  import xfer_chunker_pkg::*;

  localparam logic [31:0] FIFO_CAP = 32'(FIFO_BYTES);

  logic [31:0] room;
  logic [31:0] fifo_clip;
  logic [31:0] len_full;

  always_comb begin
    room      = room_to_edge(32'(cur_off), 32'(page_eff));
    fifo_clip = umin32(32'(rem_bytes), FIFO_CAP);
    len_full  = umin32(fifo_clip, room);
    next_len  = CHK_W'(len_full);
  end

endmodule

// File: rtl/chunk_cursor.sv
module chunk_cursor #(
  parameter int OFS_W    = 32,
  parameter int LEN_W    = 16,
  parameter int PG_W     = 16,
  parameter int CHK_W    = 7,
  parameter int DEF_PAGE = 256
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             fire_chunk,
  input  logic             advance,
  input  logic [OFS_W-1:0] in_off,
  input  logic [LEN_W-1:0] in_len,
  input  logic [PG_W-1:0]  in_page,
  input  logic [CHK_W-1:0] next_len,
  output logic [OFS_W-1:0] cur_off,
  output logic [LEN_W-1:0] rem_bytes,
  output logic [PG_W-1:0]  page_eff,
  output logic [CHK_W-1:0] held_len,
  output logic             last_chunk
);
  localparam logic [PG_W-1:0] PAGE_DFLT = PG_W'(DEF_PAGE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_off   <= '0;
      rem_bytes <= '0;
      page_eff  <= PAGE_DFLT;
      held_len  <= '0;
    end else begin
      if (load) begin
        cur_off   <= in_off;
        rem_bytes <= in_len;
        page_eff  <= (in_page == '0) ? PAGE_DFLT : in_page;
      end else if (advance) begin
        cur_off   <= cur_off + OFS_W'(held_len);
        rem_bytes <= rem_bytes - LEN_W'(held_len);
      end
      if (fire_chunk) held_len <= next_len;
    end
  end

  assign last_chunk = (rem_bytes == LEN_W'(held_len));

endmodule

// File: rtl/chunk_ctrl.sv
module chunk_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic chk_ready,
  input  logic cmp_valid,
  input  logic cmp_err,
  input  logic last_chunk,
  output logic req_ready,
  output logic chk_valid,
  output logic accept,
  output logic fire_chunk,
  output logic cmp_take,
  output logic advance,
  output logic fin_valid,
  output logic fin_err
);
  import xfer_chunker_pkg::*;

  chunk_state_e state, state_nx;

  assign req_ready  = (state == ST_IDLE);
  assign chk_valid  = (state == ST_OFFER);
  assign accept     = req_ready && req_valid;
  assign fire_chunk = chk_valid && chk_ready;
  assign cmp_take   = (state == ST_WAIT) && cmp_valid;
  assign advance    = cmp_take && !cmp_err;

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE:  if (accept) state_nx = ST_OFFER;
      ST_OFFER: if (fire_chunk) state_nx = ST_WAIT;
      ST_WAIT:  if (cmp_take) state_nx = (cmp_err || last_chunk) ? ST_IDLE : ST_OFFER;
      default:  state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      fin_valid <= 1'b0;
      fin_err   <= 1'b0;
    end else begin
      state     <= state_nx;
      fin_valid <= cmp_take && (cmp_err || last_chunk);
      fin_err   <= cmp_take && cmp_err;
    end
  end

endmodule

// File: rtl/xfer_chunker.sv
module xfer_chunker #(
  parameter int OFS_W      = 32,
  parameter int LEN_W      = 16,
  parameter int PG_W       = 16,
  parameter int FIFO_BYTES = 64,
  parameter int DEF_PAGE   = 256,
  parameter int CHK_W      = $clog2(FIFO_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [OFS_W-1:0] req_offset,
  input  logic [LEN_W-1:0] req_len,
  input  logic [PG_W-1:0]  req_page,
  output logic             chk_valid,
  input  logic             chk_ready,
  output logic [OFS_W-1:0] chk_offset,
  output logic [CHK_W-1:0] chk_len,
  input  logic             cmp_valid,
  input  logic             cmp_err,
  output logic             fin_valid,
  output logic             fin_err
);
  // Named internal events, visible to the bound checker.
  logic             accept;
  logic             fire_chunk;
  logic             cmp_take;
  logic             advance;
  logic             last_chunk;
  logic [OFS_W-1:0] cur_off;
  logic [LEN_W-1:0] rem_bytes;
  logic [PG_W-1:0]  page_eff;
  logic [CHK_W-1:0] held_len;
  logic [CHK_W-1:0] next_len;

  chunk_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .chk_ready  (chk_ready),
    .cmp_valid  (cmp_valid),
    .cmp_err    (cmp_err),
    .last_chunk (last_chunk),
    .req_ready  (req_ready),
    .chk_valid  (chk_valid),
    .accept     (accept),
    .fire_chunk (fire_chunk),
    .cmp_take   (cmp_take),
    .advance    (advance),
    .fin_valid  (fin_valid),
    .fin_err    (fin_err)
  );

  chunk_cursor #(
    .OFS_W(OFS_W), .LEN_W(LEN_W), .PG_W(PG_W), .CHK_W(CHK_W), .DEF_PAGE(DEF_PAGE)
  ) u_cursor (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (accept),
    .fire_chunk (fire_chunk),
    .advance    (advance),
    .in_off     (req_offset),
    .in_len     (req_len),
    .in_page    (req_page),
    .next_len   (next_len),
    .cur_off    (cur_off),
    .rem_bytes  (rem_bytes),
    .page_eff   (page_eff),
    .held_len   (held_len),
    .last_chunk (last_chunk)
  );

  chunk_sizer #(
    .OFS_W(OFS_W), .LEN_W(LEN_W), .PG_W(PG_W), .FIFO_BYTES(FIFO_BYTES), .CHK_W(CHK_W)
  ) u_sizer (
    .cur_off   (cur_off),
    .rem_bytes (rem_bytes),
    .page_eff  (page_eff),
    .next_len  (next_len)
  );

  assign chk_offset = cur_off;
  assign chk_len    = next_len;

endmodule

// File: rtl/xfer_chunker_chk.sv
module xfer_chunker_chk #(
  parameter int OFS_W      = 32,
  parameter int LEN_W      = 16,
  parameter int PG_W       = 16,
  parameter int FIFO_BYTES = 64,
  parameter int CHK_W      = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_ready,
  input logic             chk_valid,
  input logic             chk_ready,
  input logic [OFS_W-1:0] chk_offset,
  input logic [CHK_W-1:0] chk_len,
  input logic             fin_valid,
  input logic             fin_err,
  input logic             cmp_take,
  input logic             advance,
  input logic [LEN_W-1:0] rem_bytes,
  input logic [PG_W-1:0]  page_eff
);
  logic [31:0] pos_in_page;
  assign pos_in_page = 32'(chk_offset) & (32'(page_eff) - 32'd1);

  // R1: chunk never exceeds the FIFO nor the bytes left
  p_len_cap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    chk_valid |-> (32'(chk_len) <= 32'(FIFO_BYTES)) && (32'(chk_len) <= 32'(rem_bytes)));

  // R1: progress is made while bytes remain
  p_progress_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_valid && rem_bytes != '0) |-> (chk_len != '0));

  // R2: chunk stays inside its page
  p_no_page_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    chk_valid |-> (pos_in_page + 32'(chk_len) <= 32'(page_eff)));

  // R9: offered chunk held until taken
  p_hold_chunk_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_valid && !chk_ready) |=> (chk_valid && $stable(chk_offset) && $stable(chk_len)));

  // R8: no new request while a chunk is offered
  p_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    chk_valid |-> !req_ready);

  // R5: finish pulse comes with the block idle again
  p_fin_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fin_valid |-> (req_ready && !chk_valid));

  // R6: an error completion never advances the cursor
  p_err_no_advance_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_take && !advance) |=> (fin_valid && fin_err));

  // R5: finish is a single-cycle pulse
  p_fin_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fin_valid |=> !fin_valid);

endmodule

bind xfer_chunker xfer_chunker_chk #(
  .OFS_W(OFS_W), .LEN_W(LEN_W), .PG_W(PG_W), .FIFO_BYTES(FIFO_BYTES), .CHK_W(CHK_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_ready  (req_ready),
  .chk_valid  (chk_valid),
  .chk_ready  (chk_ready),
  .chk_offset (chk_offset),
  .chk_len    (chk_len),
  .fin_valid  (fin_valid),
  .fin_err    (fin_err),
  .cmp_take   (cmp_take),
  .advance    (advance),
  .rem_bytes  (rem_bytes),
  .page_eff   (page_eff)
);

// File: tb/xfer_chunker_test.sv
module xfer_chunker_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_offset = '0;
  logic [15:0] req_len = '0;
  logic [15:0] req_page = '0;
  logic        chk_valid;
  logic        chk_ready = 1'b0;
  logic [31:0] chk_offset;
  logic [6:0]  chk_len;
  logic        cmp_valid = 1'b0;
  logic        cmp_err = 1'b0;
  logic        fin_valid;
  logic        fin_err;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit cmp_on = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  xfer_chunker uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_offset(req_offset), .req_len(req_len), .req_page(req_page),
    .chk_valid(chk_valid), .chk_ready(chk_ready),
    .chk_offset(chk_offset), .chk_len(chk_len),
    .cmp_valid(cmp_valid), .cmp_err(cmp_err),
    .fin_valid(fin_valid), .fin_err(fin_err)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", tag, cyc, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int m_phase = 0;            // 0 idle, 1 offering, 2 waiting
  int m_off = 0, m_rem = 0, m_page = 256, m_len = 0;
  bit m_fin = 0, m_ferr = 0;
  int m_chunks = 0, m_sum = 0;

  function automatic int exp_len(input int off, input int rem, input int pg);
    int l = rem;
    int room = pg - (off % pg);
    if (l > 64) l = 64;
    if (room < l) l = room;
    return l;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_phase = 0; m_fin = 0; m_ferr = 0;
    end else begin
      m_fin = 0; m_ferr = 0;
      case (m_phase)
        0: if (req_valid) begin
             m_phase = 1; m_off = int'(req_offset); m_rem = int'(req_len);
             m_page = (req_page == 0) ? 256 : int'(req_page);
             m_chunks = 0; m_sum = 0;
           end
        1: if (chk_ready) begin
             m_len = exp_len(m_off, m_rem, m_page);
             check(((m_off % m_page) + m_len) <= m_page, "R2 page crossing", m_len, m_page);
             m_chunks++; m_sum += m_len; m_phase = 2;
           end
        default: if (cmp_valid) begin
             if (cmp_err) begin
               m_phase = 0; m_fin = 1; m_ferr = 1;
             end else begin
               m_off += m_len; m_rem -= m_len;
               if (m_rem == 0) begin m_phase = 0; m_fin = 1; end
               else m_phase = 1;
             end
           end
      endcase
    end
  end

  always @(negedge clk) begin
    if (cmp_on && rst_n) begin
      check(req_ready == (m_phase == 0), "R8 req_ready", req_ready, m_phase == 0);
      check(chk_valid == (m_phase == 1), "R4 chk_valid", chk_valid, m_phase == 1);
      if (m_phase == 1) begin
        check(int'(chk_offset) == m_off, "R4 chk_offset", chk_offset, m_off);
        check(int'(chk_len) == exp_len(m_off, m_rem, m_page), "R1 chk_len", chk_len,
              exp_len(m_off, m_rem, m_page));
      end
      check(fin_valid == m_fin, "R5 fin_valid", fin_valid, m_fin);
      if (m_fin) check(fin_err == m_ferr, "R6 fin_err", fin_err, m_ferr);
    end
  end

  // ---------------- stimulus ----------------
  task automatic run_req(input int off, input int len, input int pg,
                         input int err_at, input int exp_chunks);
    int idx = 0;
    bit done = 0;
    req_offset = 32'(off); req_len = 16'(len); req_page = 16'(pg); req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check(req_ready == 1'b0, "R8 busy after accept", req_ready, 0);
    while (!done) begin
      int stall = (idx + 1) % 3;
      logic [31:0] o0;
      logic [6:0]  l0;
      while (!chk_valid) @(negedge clk);
      o0 = chk_offset; l0 = chk_len;
      if (idx == 0 && len == 0) check(chk_len == 0, "R7 empty chunk length", chk_len, 0);
      for (int s = 0; s < stall; s++) begin
        if (s == 0 && idx == 0) begin cmp_valid = 1'b1; cmp_err = 1'b1; end
        @(negedge clk);
        cmp_valid = 1'b0; cmp_err = 1'b0;
        check(chk_valid && chk_offset == o0 && chk_len == l0, "R9 hold while stalled",
              chk_offset, o0);
        if (s == 0 && idx == 0)
          check(!fin_valid && !req_ready, "R10 stray completion while offering", fin_valid, 0);
      end
      chk_ready = 1'b1;
      @(negedge clk);
      chk_ready = 1'b0;
      repeat (idx % 2) @(negedge clk);
      cmp_valid = 1'b1; cmp_err = (idx == err_at);
      @(negedge clk);
      cmp_valid = 1'b0; cmp_err = 1'b0;
      if (req_ready) begin
        done = 1;
        check(fin_valid == 1'b1, "R5 finish pulse", fin_valid, 1);
        check(fin_err == (err_at >= 0), "R6 finish error flag", fin_err, err_at >= 0);
      end
      idx++;
    end
    check(m_chunks == exp_chunks, "R4 chunk count", m_chunks, exp_chunks);
    if (err_at < 0) check(m_sum == len, "R4 length sum", m_sum, len);
    if (len == 0) check(m_chunks == 1, "R7 one chunk for empty request", m_chunks, 1);
    repeat (2) begin
      @(negedge clk);
      check(!chk_valid && !fin_valid, "R6 quiet after finish", chk_valid, 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(req_ready == 1'b1 && chk_valid == 1'b0 && fin_valid == 1'b0, "R11 reset state",
          {req_ready, chk_valid, fin_valid}, 3'b100);
    rst_n = 1'b1;
    cmp_on = 1'b1;
    @(negedge clk);
    // R10: stray completion while idle
    cmp_valid = 1'b1;
    @(negedge clk);
    cmp_valid = 1'b0;
    check(req_ready && !fin_valid && !chk_valid, "R10 stray completion while idle", fin_valid, 0);

    run_req(0, 200, 256, -1, 4);         // FIFO-limited only
    run_req(1008, 100, 256, -1, 3);      // page edge then FIFO
    // R3: page 0 behaves as 256, first chunk is 6 bytes from offset 250
    req_offset = 32'd250; req_len = 16'd10; req_page = 16'd0; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    check(chk_valid && chk_len == 7'd6, "R3 default page size", chk_len, 6);
    chk_ready = 1'b1; @(negedge clk); chk_ready = 1'b0;
    cmp_valid = 1'b1; @(negedge clk); cmp_valid = 1'b0;
    @(negedge clk);
    check(chk_valid && chk_len == 7'd4 && chk_offset == 32'd256, "R3 default page second chunk",
          chk_len, 4);
    chk_ready = 1'b1; @(negedge clk); chk_ready = 1'b0;
    cmp_valid = 1'b1; @(negedge clk); cmp_valid = 1'b0;
    check(fin_valid && !fin_err, "R5 finish after default-page request", fin_valid, 1);

    run_req(32'h1234, 0, 256, -1, 1);    // empty request
    run_req(0, 300, 256, 1, 2);          // error on second chunk
    run_req(5, 40, 16, -1, 3);           // small page
    run_req(100, 64, 128, -1, 2);        // page edge splits a FIFO-size request
    run_req(32'h1FF00, 1000, 512, -1, 16); // mid-page long request
    run_req(1, 9, 4, -1, 3);             // tiny page
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  always @(posedge clk) begin
    if (cyc > 50000 && !finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected fewer than %0d", cyc, 50000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule